// File: doc/BRIEF.md
# I2C Bus Event Status Flags

This block sits beside an I2C byte engine and records bus events in a read-only status byte. It synchronizes the raw SDA and SCL lines through a two-stage register chain and decodes Start, Stop and SCL rising edges from them. It combines those bus conditions with the engine's state to raise five sticky flags:

- acknowledge failure
- Stop seen by a slave after an acknowledge
- lost arbitration
- misplaced Start/Stop (bus error)
- general call

The engine's state comes in as the mode, the direction, the bit position within the byte and the level the engine drives on SDA.

Software clears all flags by reading the byte, which the engine signals with a one-cycle read strobe. Disabling the peripheral holds every flag clear. An interrupt request follows the flags when interrupts are enabled. A lost arbitration also emits a one-cycle pulse that tells the engine to fall back to slave mode. The block never drives or stretches SCL.

Top module: `i2c_evt_status`

## Requirements
- R1: After synchronous reset, `status` reads 8'h00 and both `irq` and `to_slave` are 0.
- R2: `status[7:5]` always read 0. The flag bits are: bit 4 ack failure, bit 3 stop seen, bit 2 arbitration lost, bit 1 bus error, bit 0 general call. A line change at `sda_in`/`scl_in` before rising edge k is acted on at edge k+2, and the other inputs are sampled at that same edge.
- R3: Bit 4 sets on an SCL rising edge with `bit_pos` = 8 (acknowledge slot), `rx_dir` = 0 and synchronized SDA high.
- R4: Bit 3 sets on a Stop (SDA rising while SCL stays high) when `is_master` = 0 and `ack_en` = 1, provided SDA was low on an acknowledge-slot SCL rise since the last Start or Stop. With `ack_en` = 0 it stays clear.
- R5: Bit 2 sets when `is_master` = 1, `rx_dir` = 0, `bit_pos` < 8, `drv_sda` = 1 and SDA is sampled low on an SCL rise. `to_slave` is high for exactly the cycle in which bit 2 first shows that event.
- R6: With `is_master` = 1, `rx_dir` = 1 and `bit_pos` = 8, a released SDA read back low does not set bit 2 or pulse `to_slave`.
- R7: Bit 1 sets on a Start (SDA falling while SCL stays high) or a Stop while `bit_pos` is in 1 to 7. At `bit_pos` = 0 or 8 it does not set.
- R8: Bit 0 sets on the cycle after `gcal_hit` is sampled high.
- R9: `rd_strobe` clears all flags at the next edge. An event in the same cycle as the read leaves its flag set.
- R10: While `pe` = 0, all flags are held at 0 and events are ignored.
- R11: `irq` equals the `ite` value sampled at the last edge ANDed with the OR of the flags produced at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sda_in | input | 1 | Raw SDA line level |
| scl_in | input | 1 | Raw SCL line level |
| pe | input | 1 | Peripheral enable |
| ite | input | 1 | Interrupt enable |
| ack_en | input | 1 | Acknowledge enable |
| is_master | input | 1 | 1 when the engine is bus master |
| rx_dir | input | 1 | 1 when this side receives data bytes |
| bit_pos | input | BIT_W | SCL rises taken in the current byte, 8 = acknowledge slot |
| drv_sda | input | 1 | Level the engine drives on SDA (1 = released) |
| gcal_hit | input | 1 | General-call address matched strobe |
| rd_strobe | input | 1 | Status register read strobe |
| status | output | 8 | Status byte |
| irq | output | 1 | Interrupt request |
| to_slave | output | 1 | One-cycle pulse forcing slave mode |

## Verification
The hardest case to reach is a Start or Stop landing in exactly the same clock as a clearing read. A bus event reaches the flag logic only two edges after the line moves. The stimulus handles this with the general-call strobe, which is sampled directly, so the read and the event can share one edge. The other case is the acknowledge slot of a master receive, where the engine releases SDA and the line is pulled low. The bench builds this by holding master, receive direction, slot 8 and a released drive while a low SDA is clocked in. A cycle-accurate model predicts that the flag stays clear.

// File: rtl/i2c_evt_pkg.sv
package i2c_evt_pkg;
  localparam int NFLAG     = 5;
  localparam int POS_GCAL  = 0;
  localparam int POS_BERR  = 1;
  localparam int POS_ARLO  = 2;
  localparam int POS_STOPF = 3;
  localparam int POS_AF    = 4;

  // Packed MSB first: af lands on bit 4, gcal on bit 0.
  typedef struct packed {
    logic af;
    logic stopf;
    logic arlo;
    logic berr;
    logic gcal;
  } evt_t;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] raw,
  output logic [WIDTH-1:0] synced,
  output logic [WIDTH-1:0] prev
);
  // Stages 0..STAGES-1 synchronize; the extra stage holds the previous sample.
  logic [WIDTH-1:0] pipe [STAGES+1];

  for (genvar g = 0; g <= STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) pipe[g] <= '1;
        else     pipe[g] <= raw;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) pipe[g] <= '1;
        else     pipe[g] <= pipe[g-1];
      end
    end
  end

  assign synced = pipe[STAGES-1];
  assign prev   = pipe[STAGES];
endmodule

// File: rtl/i2c_bus_cond.sv
module i2c_bus_cond (
  input  logic sda_s,
  input  logic scl_s,
  input  logic sda_p,
  input  logic scl_p,
  output logic start_c,
  output logic stop_c,
  output logic scl_rise
);
  logic scl_hi;

  assign scl_hi   = scl_s & scl_p;
  assign start_c  = scl_hi &  sda_p & ~sda_s;
  assign stop_c   = scl_hi & ~sda_p &  sda_s;
  assign scl_rise = scl_s & ~scl_p;
endmodule

// File: rtl/i2c_evt_detect.sv
module i2c_evt_detect
  import i2c_evt_pkg::*;
#(
  parameter int BIT_W   = 4,
  parameter int ACK_POS = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             pe,
  input  logic             sda_s,
  input  logic             start_c,
  input  logic             stop_c,
  input  logic             scl_rise,
  input  logic             ack_en,
  input  logic             is_master,
  input  logic             rx_dir,
  input  logic [BIT_W-1:0] bit_pos,
  input  logic             drv_sda,
  input  logic             gcal_hit,
  output evt_t             evt
);
  localparam logic [BIT_W-1:0] ACK_SLOT  = BIT_W'(ACK_POS);
  localparam logic [BIT_W-1:0] LAST_DATA = BIT_W'(ACK_POS - 1);
  localparam logic [BIT_W-1:0] FIRST_MID = BIT_W'(1);

  logic ack_seen;
  logic in_ack, in_data, in_mid;

  assign in_ack  = (bit_pos == ACK_SLOT);
  assign in_data = (bit_pos <  ACK_SLOT);
  assign in_mid  = (bit_pos >= FIRST_MID) && (bit_pos <= LAST_DATA);

  // Remembers an acknowledged byte since the last Start or Stop.
  always_ff @(posedge clk) begin
    if (rst || !pe)              ack_seen <= 1'b0;
    else if (start_c || stop_c)  ack_seen <= 1'b0;
    else if (scl_rise && in_ack && !sda_s) ack_seen <= 1'b1;
  end

  always_comb begin
    evt.af    = scl_rise & in_ack & ~rx_dir & sda_s;
    evt.stopf = stop_c & ~is_master & ack_en & ack_seen;
    // Checked only on bits this side drives as transmitting master.
    evt.arlo  = is_master & ~rx_dir & in_data & drv_sda & scl_rise & ~sda_s;
    evt.berr  = (start_c | stop_c) & in_mid;
    evt.gcal  = gcal_hit;
  end

  assert_no_arlo_in_rx_ack_R6: assert property (@(posedge clk) disable iff (rst)
    (is_master && rx_dir && in_ack) |-> !evt.arlo);
  assert_berr_only_mid_byte_R7: assert property (@(posedge clk) disable iff (rst)
    evt.berr |-> (bit_pos != 0 && bit_pos < ACK_SLOT));
  assert_stopf_needs_slave_R4: assert property (@(posedge clk) disable iff (rst)
    evt.stopf |-> (!is_master && ack_en));
endmodule

// File: rtl/i2c_flag_bank.sv
module i2c_flag_bank #(
  parameter int NFLAG    = 5,
  parameter int ARLO_POS = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             pe,
  input  logic             ite,
  input  logic             rd,
  input  logic [NFLAG-1:0] evt,
  output logic [NFLAG-1:0] flags,
  output logic             irq,
  output logic             to_slave
);
  logic [NFLAG-1:0] nxt;

  for (genvar g = 0; g < NFLAG; g++) begin : g_flag
    // Event beats read: a same-cycle event survives the clear.
    assign nxt[g] = pe & ((flags[g] & ~rd) | evt[g]);
    always_ff @(posedge clk) begin
      if (rst) flags[g] <= 1'b0;
      else     flags[g] <= nxt[g];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      irq      <= 1'b0;
      to_slave <= 1'b0;
    end else begin
      irq      <= ite & (|nxt);
      to_slave <= pe & evt[ARLO_POS];
    end
  end

  assert_clear_when_off_R10: assert property (@(posedge clk) disable iff (rst)
    !pe |=> (flags == '0));
  assert_event_survives_read_R9: assert property (@(posedge clk) disable iff (rst)
    pe |=> ((flags & $past(evt)) == $past(evt)));
  assert_toslave_with_arlo_R5: assert property (@(posedge clk) disable iff (rst)
    to_slave |-> flags[ARLO_POS]);
  assert_irq_needs_enable_R11: assert property (@(posedge clk) disable iff (rst)
    irq |-> ($past(ite) && (|flags)));
endmodule

// File: rtl/i2c_evt_status.sv
module i2c_evt_status
  import i2c_evt_pkg::*;
#(
  parameter int BIT_W       = 4,
  parameter int ACK_POS     = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sda_in,
  input  logic             scl_in,
  input  logic             pe,
  input  logic             ite,
  input  logic             ack_en,
  input  logic             is_master,
  input  logic             rx_dir,
  input  logic [BIT_W-1:0] bit_pos,
  input  logic             drv_sda,
  input  logic             gcal_hit,
  input  logic             rd_strobe,
  output logic [7:0]       status,
  output logic             irq,
  output logic             to_slave
);
  localparam int STATUS_W = 8;
  localparam int PAD_W    = STATUS_W - NFLAG;

  logic [1:0]       ln_s, ln_p;
  logic             start_c, stop_c, scl_rise;
  evt_t             evt;
  logic [NFLAG-1:0] flags;

  i2c_line_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .raw({scl_in, sda_in}), .synced(ln_s), .prev(ln_p));

  i2c_bus_cond u_cond (
    .sda_s(ln_s[0]), .scl_s(ln_s[1]), .sda_p(ln_p[0]), .scl_p(ln_p[1]),
    .start_c(start_c), .stop_c(stop_c), .scl_rise(scl_rise));

  i2c_evt_detect #(.BIT_W(BIT_W), .ACK_POS(ACK_POS)) u_det (
    .clk(clk), .rst(rst), .pe(pe), .sda_s(ln_s[0]),
    .start_c(start_c), .stop_c(stop_c), .scl_rise(scl_rise),
    .ack_en(ack_en), .is_master(is_master), .rx_dir(rx_dir),
    .bit_pos(bit_pos), .drv_sda(drv_sda), .gcal_hit(gcal_hit), .evt(evt));

  i2c_flag_bank #(.NFLAG(NFLAG), .ARLO_POS(POS_ARLO)) u_bank (
    .clk(clk), .rst(rst), .pe(pe), .ite(ite), .rd(rd_strobe), .evt(evt),
    .flags(flags), .irq(irq), .to_slave(to_slave));

  assign status = {{PAD_W{1'b0}}, flags};
endmodule

// File: tb/sim_i2c_evt_status.sv
module sim_i2c_evt_status;
  logic clk = 0, rst = 1;
  logic sda_in = 1, scl_in = 1, pe = 1, ite = 0, ack_en = 0;
  logic is_master = 0, rx_dir = 0, drv_sda = 1, gcal_hit = 0, rd_strobe = 0;
  logic [3:0] bit_pos = 0;
  logic [7:0] status;
  logic irq, to_slave;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #4 clk = ~clk;

  i2c_evt_status u0 (.clk(clk), .rst(rst), .sda_in(sda_in), .scl_in(scl_in),
    .pe(pe), .ite(ite), .ack_en(ack_en), .is_master(is_master), .rx_dir(rx_dir),
    .bit_pos(bit_pos), .drv_sda(drv_sda), .gcal_hit(gcal_hit),
    .rd_strobe(rd_strobe), .status(status), .irq(irq), .to_slave(to_slave));

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // Reference model: line history (two sync stages + one previous sample)
  logic [3:0] m_sda, m_scl; // [1]=in(e-1), [2]=in(e-2), [3]=in(e-3)
  logic [7:0] m_stat;
  logic m_irq, m_ts, m_ack;
  always @(posedge clk) begin
    if (rst) begin
      m_sda = '1; m_scl = '1; m_stat = 0; m_irq = 0; m_ts = 0; m_ack = 0;
    end else begin
      logic s_d, p_d, s_c, p_c, rise, stc, spc;
      logic [4:0] ev;
      s_d = m_sda[2]; p_d = m_sda[3]; s_c = m_scl[2]; p_c = m_scl[3];
      rise = s_c && !p_c;
      stc  = s_c && p_c && p_d && !s_d;
      spc  = s_c && p_c && !p_d && s_d;
      ev[4] = rise && bit_pos == 8 && !rx_dir && s_d;
      ev[3] = spc && !is_master && ack_en && m_ack;
      ev[2] = is_master && !rx_dir && bit_pos < 8 && drv_sda && rise && !s_d;
      ev[1] = (stc || spc) && bit_pos >= 1 && bit_pos <= 7;
      ev[0] = gcal_hit;
      if (!pe) begin
        m_stat = 0; m_ack = 0;
      end else begin
        m_stat = (rd_strobe ? 8'h00 : m_stat) | {3'b000, ev};
        if (stc || spc) m_ack = 0;
        else if (rise && bit_pos == 8 && !s_d) m_ack = 1;
      end
      m_ts  = pe && ev[2];
      m_irq = ite && (m_stat != 0);
      m_sda = {m_sda[2:1], sda_in, 1'b0};
      m_scl = {m_scl[2:1], scl_in, 1'b0};
    end
  end

  // Per-cycle comparison against the model, tagged by field
  always @(negedge clk) begin
    if (!rst && !done) begin
      chk("R2",  {29'd0, status[7:5]}, {29'd0, m_stat[7:5]});
      chk("R3",  {31'd0, status[4]}, {31'd0, m_stat[4]});
      chk("R4",  {31'd0, status[3]}, {31'd0, m_stat[3]});
      chk("R5",  {31'd0, status[2]}, {31'd0, m_stat[2]});
      chk("R7",  {31'd0, status[1]}, {31'd0, m_stat[1]});
      chk("R8",  {31'd0, status[0]}, {31'd0, m_stat[0]});
      chk("R11", {31'd0, irq}, {31'd0, m_irq});
      chk("R5 to_slave", {31'd0, to_slave}, {31'd0, m_ts});
    end
  end

  task automatic wt(int n); repeat (n) @(negedge clk); endtask
  task automatic ln(logic d, logic c); @(negedge clk); sda_in = d; scl_in = c; wt(4); endtask
  task automatic rd(); @(negedge clk); rd_strobe = 1; @(negedge clk); rd_strobe = 0; wt(1); endtask

  initial begin
    wt(3);
    chk("R1 status", {24'd0, status}, 32'h00);
    chk("R1 irq", {31'd0, irq}, 0);
    chk("R1 to_slave", {31'd0, to_slave}, 0);
    @(negedge clk); rst = 0; wt(4);

    // R3: ack failure, interrupt enabled
    ite = 1; is_master = 1; rx_dir = 0; bit_pos = 8; drv_sda = 1;
    ln(1, 0); ln(1, 1);
    chk("R3 af", {24'd0, status}, 32'h10);
    chk("R11 irq on", {31'd0, irq}, 1);
    rd();
    chk("R9 read clears", {24'd0, status}, 32'h00);

    // R4: slave ack then stop with ack_en=1
    is_master = 0; ack_en = 1;
    ln(1, 0); ln(0, 0); ln(0, 1); ln(0, 0); ln(0, 1); ln(1, 1);
    chk("R4 stopf", {24'd0, status}, 32'h08);
    rd();
    ack_en = 0;
    ln(1, 0); ln(0, 0); ln(0, 1); ln(1, 1);
    chk("R4 no stopf ack_en=0", {24'd0, status}, 32'h00);

    // R5: arbitration lost on data bit 3
    is_master = 1; rx_dir = 0; bit_pos = 3; drv_sda = 1;
    ln(1, 0); ln(0, 0); ln(0, 1);
    chk("R5 arlo", {24'd0, status}, 32'h04);
    rd();

    // R6: master receive ack slot, released SDA read low
    rx_dir = 1; bit_pos = 8;
    ln(0, 0); ln(0, 1);
    chk("R6 no arlo", {24'd0, status}, 32'h00);
    chk("R6 no to_slave", {31'd0, to_slave}, 0);

    // R7: misplaced start at bit 4, then a start at bit 0
    is_master = 0; rx_dir = 0; bit_pos = 4;
    ln(0, 0); ln(1, 0); ln(1, 1); ln(0, 1);
    chk("R7 berr", {24'd0, status}, 32'h02);
    rd();
    bit_pos = 0;
    ln(0, 0); ln(1, 0); ln(1, 1); ln(0, 1);
    chk("R7 no berr at bit 0", {24'd0, status}, 32'h00);

    // R8 and R9: general call, coincident read
    @(negedge clk); gcal_hit = 1; @(negedge clk); gcal_hit = 0; wt(1);
    chk("R8 gcal", {24'd0, status}, 32'h01);
    @(negedge clk); gcal_hit = 1; rd_strobe = 1;
    @(negedge clk); gcal_hit = 0; rd_strobe = 0; wt(1);
    chk("R9 event wins", {24'd0, status}, 32'h01);
    ite = 0; wt(2);
    chk("R11 irq off", {31'd0, irq}, 0);

    // R10: disable clears and ignores events
    @(negedge clk); pe = 0; wt(2);
    chk("R10 cleared", {24'd0, status}, 32'h00);
    @(negedge clk); gcal_hit = 1; @(negedge clk); gcal_hit = 0; wt(2);
    chk("R10 ignored", {24'd0, status}, 32'h00);
    pe = 1; wt(3);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule